// File: doc/BRIEF.md
# Data-Strobe Serial Transmitter

This block sits between a link-layer controller and an external line driver. Each link-clock period, the link hands over a pair of bits in parallel. The block sends them out one after the other on a serial data line, paired with a strobe line. The strobe changes only when the data does not, so the receiver can recover the bit clock from the XOR of the two lines. The block also produces the link clock, by dividing its reference clock, and an active-low enable that switches on the external driver while bits are being sent.

All logic runs on the reference clock. In full-rate mode each serial bit lasts one reference cycle, so the link clock is the reference divided by two. In half-rate mode an extra prescale step stretches each bit to two reference cycles, which halves both the bit rate and the link clock from the same oscillator. The link presents a new pair, and its transmit request, while the link clock is low. The block captures them on the reference edge that raises the link clock.

Top module: `ds_tx`

## Requirements
- R1: After reset, `link_clk_o`, `data_o` and `strobe_o` are 0 and `drv_en_no` is 1.
- R2: `link_clk_o` toggles once per bit period. A bit period is one reference cycle in full-rate mode (`full_rate_i`=1) and two reference cycles in half-rate mode (`full_rate_i`=0).
- R3: `tx_bits_i` and `tx_en_i` are captured on the edge that raises `link_clk_o`. `tx_bits_i[0]` appears on `data_o` from that edge while `link_clk_o` is high. `tx_bits_i[1]` appears from the following falling edge of `link_clk_o` while it is low.
- R4: For each transmitted bit, `strobe_o` inverts when the bit equals the previous level of `data_o`, and holds otherwise. `data_o` and `strobe_o` never change on the same reference edge.
- R5: `drv_en_no` goes low on the edge that raises `link_clk_o` when `tx_en_i` was 1. It stays low through both bit slots of that link period. It only falls on an edge that raises `link_clk_o`.
- R6: When a pair is captured with `tx_en_i`=0, `drv_en_no` is 1 for that link period, and `data_o` and `strobe_o` keep their previous levels.
- R7: The same serialization and strobe rules apply in both rate modes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| full_rate_i | input | 1 | 1: full rate, 0: half rate |
| tx_en_i | input | 1 | Transmit request for the presented pair |
| tx_bits_i | input | 2 | Bit pair; bit 0 is sent first |
| link_clk_o | output | 1 | Link clock derived from the reference |
| data_o | output | 1 | Serial data line |
| strobe_o | output | 1 | Strobe line |
| drv_en_no | output | 1 | Active-low external driver enable |

## Verification
The assertions hold on every cycle for four properties. Data and strobe never switch together. Both lines stay still while the driver is disabled. The enable falls only as the link clock rises. The half-rate prescaler never issues two bit ticks in a row.

Only the directed scenarios can show the rest, because it needs the expected bit stream. That covers bit order within a pair, the exact strobe level after each bit, the slot lengths in each mode, and that an idle period freezes the lines. The scenarios run alternating, repeated and mixed patterns in both rates, and cover idle gaps and restarts.

// File: rtl/ds_tx_pkg.sv
package ds_tx_pkg;
  localparam int unsigned PAIR_W = 2;
  typedef logic [PAIR_W-1:0] pair_t;

  typedef struct packed {
    logic vld;   // a bit is to be sent this tick
    logic val;
    logic idle;  // link period captured without request
  } bit_req_t;
endpackage

// File: rtl/ds_clk_gen.sv
module ds_clk_gen (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic full_rate_i,
  output logic tick_o,
  output logic phase_o
);
  logic pre_q, phase_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_q <= 1'b0;
    else         pre_q <= ~pre_q;
  end

  assign tick_o = full_rate_i | pre_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     phase_q <= 1'b0;
    else if (tick_o) phase_q <= ~phase_q;
  end

  assign phase_o = phase_q;

  p_half_spacing_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!full_rate_i && tick_o) |=> (full_rate_i || !tick_o));

  p_phase_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (phase_q != $past(phase_q)));
endmodule

// File: rtl/ds_serializer.sv
module ds_serializer
  import ds_tx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     tick_i,
  input  logic     phase_i,
  input  logic     tx_en_i,
  input  pair_t    bits_i,
  output bit_req_t req_o
);
  logic hold_q, act_q;
  logic capture;

  assign capture = tick_i & ~phase_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= 1'b0;
      act_q  <= 1'b0;
    end else if (capture) begin
      hold_q <= bits_i[1];
      act_q  <= tx_en_i;
    end
  end

  always_comb begin
    req_o.vld  = tick_i & (phase_i ? act_q : tx_en_i);
    req_o.val  = phase_i ? hold_q : bits_i[0];
    req_o.idle = capture & ~tx_en_i;
  end
endmodule

// File: rtl/ds_strobe_enc.sv
module ds_strobe_enc
  import ds_tx_pkg::*;
(
  input  logic     clk_i,
  input  logic     rst_ni,
  input  bit_req_t req_i,
  input  logic     phase_i,
  output logic     data_o,
  output logic     strobe_o,
  output logic     drv_en_no
);
  logic data_q, strb_q, den_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= 1'b0;
      strb_q <= 1'b0;
      den_nq <= 1'b1;
    end else if (req_i.vld) begin
      data_q <= req_i.val;
      if (req_i.val == data_q) strb_q <= ~strb_q;
      den_nq <= 1'b0;
    end else if (req_i.idle) begin
      den_nq <= 1'b1;
    end
  end

  assign data_o    = data_q;
  assign strobe_o  = strb_q;
  assign drv_en_no = den_nq;

  p_one_line_moves_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(data_q) || $stable(strb_q));

  p_idle_frozen_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (den_nq && $past(den_nq)) |-> ($stable(data_q) && $stable(strb_q)));

  p_enable_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(den_nq) |-> phase_i);
endmodule

// File: rtl/ds_tx.sv
module ds_tx
  import ds_tx_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        full_rate_i,
  input  logic        tx_en_i,
  input  logic [1:0]  tx_bits_i,
  output logic        link_clk_o,
  output logic        data_o,
  output logic        strobe_o,
  output logic        drv_en_no
);
  logic     tick, phase;
  bit_req_t req;

  ds_clk_gen u_clk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .full_rate_i(full_rate_i),
    .tick_o     (tick),
    .phase_o    (phase)
  );

  ds_serializer u_ser (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .tick_i (tick),
    .phase_i(phase),
    .tx_en_i(tx_en_i),
    .bits_i (tx_bits_i),
    .req_o  (req)
  );

  ds_strobe_enc u_enc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .req_i    (req),
    .phase_i  (phase),
    .data_o   (data_o),
    .strobe_o (strobe_o),
    .drv_en_no(drv_en_no)
  );

  assign link_clk_o = phase;
endmodule

// File: tb/tb_ds_tx.sv
module tb_ds_tx;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       full_rate_i = 1'b1;
  logic       tx_en_i = 1'b0;
  logic [1:0] tx_bits_i = 2'b00;
  logic       link_clk_o, data_o, strobe_o, drv_en_no;

  int checks = 0;
  int errors = 0;
  logic exp_d, exp_s;

  always #10 clk = ~clk;

  ds_tx dut (
    .clk_i(clk), .rst_ni(rst_ni), .full_rate_i(full_rate_i),
    .tx_en_i(tx_en_i), .tx_bits_i(tx_bits_i), .link_clk_o(link_clk_o),
    .data_o(data_o), .strobe_o(strobe_o), .drv_en_no(drv_en_no)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_link(input logic lvl, output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (link_clk_o !== lvl && n < 20);
  endtask

  task automatic apply_bit(input logic b);
    if (b == exp_d) exp_s = ~exp_s;
    exp_d = b;
  endtask

  // one link period: drive pair while link clock is low, check both slots
  task automatic send_pair(input logic en, input logic [1:0] b);
    int n;
    tx_en_i = en;
    tx_bits_i = b;
    wait_link(1'b1, n);
    if (en) apply_bit(b[0]);
    chk("R3 slot0 data", {7'd0, data_o}, {7'd0, exp_d});
    chk("R4 slot0 strobe", {7'd0, strobe_o}, {7'd0, exp_s});
    chk(en ? "R5 enable low" : "R6 enable high", {7'd0, drv_en_no}, {7'd0, ~en});
    wait_link(1'b0, n);
    chk("R2 high length", n[7:0], full_rate_i ? 8'd1 : 8'd2);
    if (en) apply_bit(b[1]);
    chk("R3 slot1 data", {7'd0, data_o}, {7'd0, exp_d});
    chk("R4 slot1 strobe", {7'd0, strobe_o}, {7'd0, exp_s});
    chk("R5 enable held", {7'd0, drv_en_no}, {7'd0, ~en});
  endtask

  task automatic do_reset(input logic fr);
    rst_ni = 1'b0;
    full_rate_i = fr;
    tx_en_i = 1'b0;
    repeat (3) @(negedge clk);
    chk("R1 link clk", {7'd0, link_clk_o}, 8'd0);
    chk("R1 data", {7'd0, data_o}, 8'd0);
    chk("R1 strobe", {7'd0, strobe_o}, 8'd0);
    chk("R1 enable", {7'd0, drv_en_no}, 8'd1);
    exp_d = 1'b0;
    exp_s = 1'b0;
    rst_ni = 1'b1;
  endtask

  task automatic t_full_patterns;
    do_reset(1'b1);
    send_pair(1'b1, 2'b00);
    send_pair(1'b1, 2'b11);
    send_pair(1'b1, 2'b10);
    send_pair(1'b1, 2'b01);
    send_pair(1'b1, 2'b01);
  endtask

  task automatic t_idle_gap;
    do_reset(1'b1);
    send_pair(1'b1, 2'b10);
    send_pair(1'b0, 2'b01);  // R6: pair ignored
    send_pair(1'b0, 2'b11);
    send_pair(1'b1, 2'b11);
  endtask

  task automatic t_half_patterns;
    do_reset(1'b0);  // R7
    send_pair(1'b1, 2'b01);
    send_pair(1'b1, 2'b00);
    send_pair(1'b0, 2'b10);
    send_pair(1'b1, 2'b10);
    send_pair(1'b1, 2'b11);
  endtask

  initial begin
    t_full_patterns();
    t_idle_gap();
    t_half_patterns();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule